// File: doc/BRIEF.md
# Chained Dual 8-bit Timer Pair

Two 8-bit up-counters sit side by side. Each one picks a clock source through a 2-bit selector, compares its count with an 8-bit threshold and emits a one-cycle match pulse. The interrupt and DMA request logic downstream takes these pulses. The first counter can count pulses from a horizontal-interrupt line. Each such pulse is held as pending until the counter takes it. The second counter can count the first counter's matches, which chains the pair into a 16-bit-style cascade.

The prescaler is outside this block. It supplies single-cycle strobes at divide-by-1, 4, 16 and 256. The run bits, the mode field and the thresholds come from registers that are also outside this block. Every count update, match and chain step takes effect on one rising clock edge. The match pulses are registered.

Top module: `tmr_pair_chained`

## Requirements
- R1: A counter whose run bit is low (bit 0 for timer 0, bit 1 for timer 1) holds its count and raises no match.
- R2: Timer 0 steps on the source picked by mode[1:0]: 0 = pending horizontal pulse, 1 = divide-by-1 strobe, 2 = divide-by-4 strobe, 3 = divide-by-16 strobe.
- R3: Timer 1 steps on the source picked by mode[3:2]: 0 = timer 0 match (chain), 1 = divide-by-1 strobe, 2 = divide-by-16 strobe, 3 = divide-by-256 strobe.
- R4: A horizontal pulse stays pending until timer 0 counts it in mode 0 while running. Each pending pulse gives exactly one increment. Pulses that arrive while the counter is stopped give a single step once it runs.
- R5: When the threshold is non-zero and the stepped count is greater than or equal to it, the count becomes 0 on that edge and the match output is high for the following cycle only.
- R6: A threshold of 0 never matches, and the count wraps from 255 to 0.
- R7: In chain mode timer 1 advances on the same edge on which timer 0 matches, and at no other time.
- R8: After reset both counts, both match outputs and the pending horizontal flag are 0.
- R9: A running counter whose threshold is lowered to or below its current count matches on the next edge even with no source step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 2 | Run enables; bit 0 timer 0, bit 1 timer 1 |
| mode_i | input | 4 | [1:0] timer 0 source, [3:2] timer 1 source |
| thr0_i | input | 8 | Timer 0 threshold, 0 disables match |
| thr1_i | input | 8 | Timer 1 threshold, 0 disables match |
| tick_div1_i | input | 1 | Divide-by-1 strobe |
| tick_div4_i | input | 1 | Divide-by-4 strobe |
| tick_div16_i | input | 1 | Divide-by-16 strobe |
| tick_div256_i | input | 1 | Divide-by-256 strobe |
| hint_i | input | 1 | Horizontal-interrupt pulse |
| count0_o | output | 8 | Timer 0 count |
| count1_o | output | 8 | Timer 1 count |
| match0_o | output | 1 | Timer 0 match pulse |
| match1_o | output | 1 | Timer 1 match pulse |

## Verification
The bench targets these corner cases:

- **Wrap past 255 with a zero threshold.** A design that treats 0 as a live threshold would match on every step instead.
- **Horizontal pulses that arrive while timer 0 is stopped.** A design that drops the pending flag would never step. One that fails to clear it would step on every cycle.
- **Chain alignment.** A design that registers the timer 0 match before feeding timer 1 lags by one cycle, and the per-cycle comparison shows the mismatch.
- **Threshold lowered below a count that is not moving.** A design that only compares when the count steps misses this match.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  typedef struct packed {
    logic d1;
    logic d4;
    logic d16;
    logic d256;
  } tick_bus_t;

  typedef enum logic [1:0] {
    T0_HINT  = 2'd0,
    T0_DIV1  = 2'd1,
    T0_DIV4  = 2'd2,
    T0_DIV16 = 2'd3
  } t0_src_e;

  typedef enum logic [1:0] {
    T1_CHAIN  = 2'd0,
    T1_DIV1   = 2'd1,
    T1_DIV16  = 2'd2,
    T1_DIV256 = 2'd3
  } t1_src_e;

endpackage

// File: rtl/tmr_hint_latch.sv
module tmr_hint_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  input  logic consume_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (consume_i) pend_d = 1'b0;
    if (pulse_i)   pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R4
  consume_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume_i |-> pend_q);
  // R4
  consume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume_i && !pulse_i) |=> !pend_q);
  // R4
  pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> pend_q);
endmodule

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_pair_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [1:0] sel_i,
  input  tick_bus_t  ticks_i,
  input  logic       alt_i,
  output logic       step_o
);
  generate
    if (IDX == 0) begin : g_first
      always_comb begin
        unique case (t0_src_e'(sel_i))
          T0_HINT:  step_o = alt_i;
          T0_DIV1:  step_o = ticks_i.d1;
          T0_DIV4:  step_o = ticks_i.d4;
          default:  step_o = ticks_i.d16;
        endcase
      end
    end else begin : g_second
      always_comb begin
        unique case (t1_src_e'(sel_i))
          T1_CHAIN:  step_o = alt_i;
          T1_DIV1:   step_o = ticks_i.d1;
          T1_DIV16:  step_o = ticks_i.d16;
          default:   step_o = ticks_i.d256;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         step_i,
  input  logic [W-1:0] thr_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_now_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_d, sum;
  logic         hit_q, hit_d, cnt_en;

  always_comb begin
    sum    = cnt_q + W'(step_i);
    hit_d  = run_i && (thr_i != '0) && (sum >= thr_i);
    cnt_en = run_i;
    cnt_d  = hit_d ? '0 : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign cnt_o     = cnt_q;
  assign hit_now_o = hit_d;
  assign hit_o     = hit_q;

  // R1
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));
  // R1
  stopped_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !hit_q);
  // R5
  hit_zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> (cnt_q == '0));
  // R6
  zero_thr_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_i == '0) |=> !hit_q);
endmodule

// File: rtl/tmr_pair_chained.sv
module tmr_pair_chained
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       run_i,
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] thr0_i,
  input  logic [CNT_W-1:0] thr1_i,
  input  logic             tick_div1_i,
  input  logic             tick_div4_i,
  input  logic             tick_div16_i,
  input  logic             tick_div256_i,
  input  logic             hint_i,
  output logic [CNT_W-1:0] count0_o,
  output logic [CNT_W-1:0] count1_o,
  output logic             match0_o,
  output logic             match1_o
);
  tick_bus_t  ticks;
  logic [1:0] sel0, sel1;
  logic       hint_pend, hint_take;
  logic       step0, step1, hit_now0, hit_now1;

  assign ticks = '{d1: tick_div1_i, d4: tick_div4_i, d16: tick_div16_i, d256: tick_div256_i};
  assign sel0  = mode_i[1:0];
  assign sel1  = mode_i[3:2];
  assign hint_take = run_i[0] && (t0_src_e'(sel0) == T0_HINT) && hint_pend;

  tmr_hint_latch u_hint (
    .clk(clk), .rst_n(rst_n), .pulse_i(hint_i),
    .consume_i(hint_take), .pend_o(hint_pend)
  );

  tmr_src_sel #(.IDX(0)) u_sel0 (
    .sel_i(sel0), .ticks_i(ticks), .alt_i(hint_pend), .step_o(step0)
  );

  tmr_counter #(.W(CNT_W)) u_cnt0 (
    .clk(clk), .rst_n(rst_n), .run_i(run_i[0]), .step_i(step0), .thr_i(thr0_i),
    .cnt_o(count0_o), .hit_now_o(hit_now0), .hit_o(match0_o)
  );

  tmr_src_sel #(.IDX(1)) u_sel1 (
    .sel_i(sel1), .ticks_i(ticks), .alt_i(hit_now0), .step_o(step1)
  );

  tmr_counter #(.W(CNT_W)) u_cnt1 (
    .clk(clk), .rst_n(rst_n), .run_i(run_i[1]), .step_i(step1), .thr_i(thr1_i),
    .cnt_o(count1_o), .hit_now_o(hit_now1), .hit_o(match1_o)
  );

  // R7
  chain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i[1] && sel1 == 2'd0 && !hit_now0) |=> $stable(count1_o));
  // R7
  chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i[1] && sel1 == 2'd0 && hit_now0 && !hit_now1)
      |=> (count1_o == $past(count1_o) + 1'b1));
  // R4
  hint_mode_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i[0] && sel0 == 2'd0 && !hint_pend && !hit_now0) |=> $stable(count0_o));
endmodule

// File: tb/tmr_pair_chained_tb.sv
`timescale 1ns/1ps
module tmr_pair_chained_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] run;
  logic [3:0] mode;
  logic [7:0] thr0, thr1;
  logic       d1, d4, d16, d256, hint;
  logic [7:0] count0, count1;
  logic       match0, match1;

  int checks = 0, fails = 0, cyc = 0, hint_per = 0;
  bit en1, en4, en16, en256;
  string tag = "R8";

  int m_c0, m_c1;
  bit m_m0, m_m1, m_pend;

  always #2 clk = ~clk;

  tmr_pair_chained u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .mode_i(mode), .thr0_i(thr0), .thr1_i(thr1),
    .tick_div1_i(d1), .tick_div4_i(d4), .tick_div16_i(d16), .tick_div256_i(d256),
    .hint_i(hint), .count0_o(count0), .count1_o(count1), .match0_o(match0), .match1_o(match1)
  );

  // Behavioural reference built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c0 = 0; m_c1 = 0; m_m0 = 0; m_m1 = 0; m_pend = 0;
    end else begin
      bit s0, s1, took;
      int c;
      case (mode[1:0])
        2'd0: s0 = m_pend;
        2'd1: s0 = d1;
        2'd2: s0 = d4;
        default: s0 = d16;
      endcase
      took = run[0] && mode[1:0] == 2'd0 && m_pend;
      m_m0 = 0;
      if (run[0]) begin
        c = (m_c0 + int'(s0)) % 256;
        if (thr0 != 0 && c >= thr0) begin c = 0; m_m0 = 1; end
        m_c0 = c;
      end
      case (mode[3:2])
        2'd0: s1 = m_m0;
        2'd1: s1 = d1;
        2'd2: s1 = d16;
        default: s1 = d256;
      endcase
      m_m1 = 0;
      if (run[1]) begin
        c = (m_c1 + int'(s1)) % 256;
        if (thr1 != 0 && c >= thr1) begin c = 0; m_m1 = 1; end
        m_c1 = c;
      end
      if (hint) m_pend = 1;
      else if (took) m_pend = 0;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    checks++;
    if (count0 !== m_c0[7:0] || count1 !== m_c1[7:0] || match0 !== m_m0 || match1 !== m_m1) begin
      fails++;
      $display("FAIL %s cyc=%0d actual c0=%0d c1=%0d m0=%0b m1=%0b expected c0=%0d c1=%0d m0=%0b m1=%0b",
               tag, cyc, count0, count1, match0, match1, m_c0, m_c1, m_m0, m_m1);
    end
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      d1   = en1;
      d4   = en4   && (cyc % 4 == 0);
      d16  = en16  && (cyc % 16 == 0);
      d256 = en256 && (cyc % 256 == 0);
      hint = (hint_per != 0) && (cyc % hint_per == 0);
      cyc++;
      @(negedge clk);
      compare();
    end
    d1 = 0; d4 = 0; d16 = 0; d256 = 0; hint = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; run = 0; mode = 0; thr0 = 0; thr1 = 0;
    d1 = 0; d4 = 0; d16 = 0; d256 = 0; hint = 0;
    en1 = 0; en4 = 0; en16 = 0; en256 = 0; hint_per = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int held;
    do_reset();
    // R8 reset state
    @(negedge clk);
    check("R8 count0", count0, 0); check("R8 count1", count1, 0);
    check("R8 match", {match1, match0}, 0);

    // R2 / R6: divide-by-1, zero threshold, wrap
    tag = "R2"; run = 2'b01; mode = 4'b0001; en1 = 1;
    run_cycles(255);
    check("R6 count0 at 255", count0, 255);
    tag = "R6"; run_cycles(1);
    check("R6 wrap to 0", count0, 0);
    check("R6 no match", match0, 0);
    tag = "R2"; en1 = 0; en4 = 1; mode = 4'b0010; run_cycles(40);
    en16 = 1; mode = 4'b0011; run_cycles(80);

    // R1 stopped hold
    tag = "R1"; held = count0; run = 2'b00; en1 = 1; en4 = 1; en16 = 1; en256 = 1;
    mode = 4'b0101; run_cycles(20);
    check("R1 count0 held", count0, held);
    check("R1 count1 held", count1, 0);

    // R5 match and reset
    do_reset(); tag = "R5"; run = 2'b01; mode = 4'b0001; thr0 = 8'd5; en1 = 1;
    run_cycles(5);
    check("R5 match0 high", match0, 1); check("R5 count0 cleared", count0, 0);
    run_cycles(1);
    check("R5 match0 one cycle", match0, 0); check("R5 count0 restarted", count0, 1);
    run_cycles(30);

    // R9 lowered threshold, no step
    do_reset(); tag = "R9"; run = 2'b01; mode = 4'b0001; en1 = 1;
    run_cycles(100);
    en1 = 0; thr0 = 8'd50; run_cycles(1);
    check("R9 match0", match0, 1); check("R9 count0", count0, 0);
    run_cycles(3);

    // R4 horizontal pulses
    do_reset(); tag = "R4"; mode = 4'b0000; hint_per = 2; run_cycles(6);
    hint_per = 0; run_cycles(3);
    check("R4 stopped no count", count0, 0);
    run = 2'b01; run_cycles(1);
    check("R4 one step", count0, 1);
    run_cycles(4);
    check("R4 no extra step", count0, 1);
    hint_per = 3; thr0 = 8'd7; run_cycles(60);

    // R7 chain
    do_reset(); tag = "R7"; run = 2'b11; mode = 4'b0001; thr0 = 8'd3; thr1 = 8'd4; en1 = 1;
    run_cycles(3);
    check("R7 match0", match0, 1); check("R7 count1 same edge", count1, 1);
    run_cycles(9);
    check("R7 match1", match1, 1); check("R7 count1 cleared", count1, 0);
    run_cycles(40);

    // R3 timer 1 sources
    do_reset(); tag = "R3"; run = 2'b10; en1 = 1; en16 = 1; en256 = 1;
    mode = 4'b0100; run_cycles(30);
    check("R3 div1 count1", count1, 30);
    mode = 4'b1000; run_cycles(320);
    mode = 4'b1100; thr1 = 8'd2; run_cycles(600);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule